// File: doc/BRIEF.md
# Keyed Watchdog Reset Controller

This block is the watchdog side of a 64-bit timer. It is armed only through a fixed two-step key ritual, and once armed it cannot be turned off by software. Software writes a 32-bit control word that carries an enable flag and a 16-bit key. It must first write the arming key and then the go key, each with the enable flag set. After that the block runs a 64-bit up-counter. The counter is built from two 32-bit halves joined by a carry, and it is compared against a 64-bit period.

While the block runs, software services it by writing the arming key and then the go key again, which restarts the count from zero. Two events end the run. One is the counter reaching the period. The other is any write that carries a key other than the one expected at that point. Either event drives a system reset pulse of fixed length, after which the block falls back to its disarmed state.

The block acts only while the surrounding timer is configured for watchdog mode and both of its halves are out of reset. Otherwise it freezes.

Top module: `wdog_keyed_reset`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), wd_state reads 0 (disarmed), sys_rst is 0 and count is 0.
- R2: The block is enabled only while tmode equals 2'b10 and half_run equals 2'b11. While it is not enabled and not pulsing, writes are ignored and both wd_state and count hold their values.
- R3: In state 0, a write whose bits 31:16 equal 16'hA5C6 and whose bit 14 is 1 moves the block to state 1 (primed). Any other write in state 0 leaves it in state 0.
- R4: In state 1, a write whose bits 31:16 equal 16'hDA7E and whose bit 14 is 1 moves the block to state 2 (running) with count 0. Any other write in state 1 leaves it in state 1.
- R5: In states 2 and 3, count rises by one on every enabled clock edge, starting from 0 on entry. In states 0 and 1, count reads 0.
- R6: When count equals {period_hi, period_lo} at an enabled edge in state 2 or 3, sys_rst is 1 from the next cycle on. This timeout takes precedence over a write made at the same edge.
- R7: In state 2, a write with key 16'hA5C6 moves the block to state 3. In state 3, a write with key 16'hDA7E returns it to state 2 and clears count to 0. Bit 14 is ignored in states 2 and 3.
- R8: A write in state 2 whose key is not 16'hA5C6, or a write in state 3 whose key is not 16'hDA7E, raises sys_rst in the cycle right after the write. Control word 32'h0000_4000 is one such write.
- R9: sys_rst stays 1 for exactly PULSE_LEN (default 16) consecutive cycles, with wd_state reading 4 throughout. The block then returns to state 0 with count 0.
- R10: No write can take the block from state 2 or 3 back to state 0 or 1. The only way out is the reset pulse.
- R11: During the pulse, writes and the enable condition have no effect on its length or on the state reached after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmode | input | 2 | Global timer-mode field; 2'b10 selects watchdog |
| half_run | input | 2 | Per-half run flags; both must be 1 |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word: key in 31:16, enable in bit 14 |
| period_lo | input | 32 | Low half of the timeout period |
| period_hi | input | 32 | High half of the timeout period |
| sys_rst | output | 1 | System reset pulse |
| wd_state | output | 3 | 0 disarmed, 1 primed, 2 running, 3 half-serviced, 4 pulsing |
| count | output | 64 | Joined timeout counter |

## Verification
The assertions check on every cycle the properties that hold at every edge. The pulse never runs longer than PULSE_LEN and always ends in state 0. The primed and running states are entered only from their single legal predecessor. A running block never drops back to state 0 or 1 by a write. A wrong key in state 2 is followed by a reset, and a frozen block holds both its state and its count. Some behaviour depends on exact cycle counts and on ordered stimulus, so only the bench scenarios show it: the exact timeout cycle for each period, the service restart, precedence of a timeout over a same-edge write, and writes ignored during a pulse.

// File: rtl/wdk_pkg.sv
// Shared types for the keyed watchdog.
// Assumes: state codes are observed by software and by the bench, so the
// encoding below is fixed.
package wdk_pkg;

    typedef enum logic [2:0] {
        WDS_IDLE     = 3'd0,
        WDS_PRE      = 3'd1,
        WDS_RUN      = 3'd2,
        WDS_RUN_HALF = 3'd3,
        WDS_FIRE     = 3'd4
    } wds_e;

endpackage

// File: rtl/wdk_key_decode.sv
// Splits a control word into its enable flag and two key matches.
// Assumes: key field and enable position fit inside CTRL_W.
module wdk_key_decode #(
    parameter int unsigned CTRL_W  = 32,
    parameter int unsigned KEY_LSB = 16,
    parameter int unsigned KEY_W   = 16,
    parameter int unsigned EN_POS  = 14,
    parameter logic [KEY_W-1:0] KEY_ARM = 16'hA5C6,
    parameter logic [KEY_W-1:0] KEY_GO  = 16'hDA7E
) (
    input  logic [CTRL_W-1:0] word,
    output logic              en_bit,
    output logic              arm_hit,
    output logic              go_hit
);

    logic [KEY_W-1:0] key_field;

    // Field extraction and key comparison.
    always_comb begin
        key_field = word[KEY_LSB +: KEY_W];
        en_bit    = word[EN_POS];
        arm_hit   = (key_field == KEY_ARM);
        go_hit    = (key_field == KEY_GO);
    end

endmodule

// File: rtl/wdk_span_counter.sv
// Up-counter built from HALVES equal slices chained by carry, with a
// full-width match against the period.
// Assumes: clr wins over inc; the count wraps silently past all ones.
module wdk_span_counter #(
    parameter int unsigned HALF_W = 32,
    parameter int unsigned HALVES = 2,
    localparam int unsigned CNT_W = HALF_W * HALVES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);

    logic [HALF_W-1:0] slice_q [HALVES];
    logic [HALVES-1:0] step;

    for (genvar g = 0; g < HALVES; g++) begin : g_slice
        if (g == 0) begin : g_first
            assign step[g] = inc;
        end else begin : g_rest
            assign step[g] = step[g-1] && (&slice_q[g-1]);
        end

        // Slice register: clear, or advance when all lower slices carry.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                slice_q[g] <= '0;
            end else if (step[g]) begin
                slice_q[g] <= slice_q[g] + 1'b1;
            end
        end

        assign cnt[g*HALF_W +: HALF_W] = slice_q[g];
    end

    // Full-width period match.
    always_comb begin
        hit = (cnt == period);
    end

endmodule

// File: rtl/wdk_rst_pulse.sv
// Fixed-length pulse generator for the system reset output.
// Assumes: LEN >= 1; a start while active is not expected.
module wdk_rst_pulse #(
    parameter int unsigned LEN = 16,
    localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic last
);

    logic [CW-1:0] left_q;
    logic          act_q;

    // Pulse timer: load on start, count down, drop after the final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            left_q <= '0;
        end else if (start) begin
            act_q  <= 1'b1;
            left_q <= CW'(LEN - 1);
        end else if (act_q) begin
            if (left_q == '0) begin
                act_q <= 1'b0;
            end else begin
                left_q <= left_q - 1'b1;
            end
        end
    end

    assign active = act_q;
    assign last   = act_q && (left_q == '0);

endmodule

// File: rtl/wdk_seq_fsm.sv
// Key sequencing state machine: arming, servicing, bad-key and timeout
// detection, and hand-off to the pulse generator.
// Assumes: the enable condition gates every move except the pulse exit;
// a timeout has precedence over a same-edge write.
module wdk_seq_fsm
    import wdk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    input  logic wr,
    input  logic en_bit,
    input  logic arm_hit,
    input  logic go_hit,
    input  logic hit,
    input  logic pulse_last,
    output wds_e state,
    output logic cnt_clr,
    output logic cnt_inc,
    output logic pulse_start
);

    wds_e state_q, state_d;
    logic service;
    logic running;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        service = 1'b0;
        unique case (state_q)
            WDS_IDLE: begin
                if (gate && wr && en_bit && arm_hit) state_d = WDS_PRE;
            end
            WDS_PRE: begin
                if (gate && wr && en_bit && go_hit) state_d = WDS_RUN;
            end
            WDS_RUN: begin
                if (gate) begin
                    if (hit) begin
                        state_d = WDS_FIRE;
                    end else if (wr) begin
                        state_d = arm_hit ? WDS_RUN_HALF : WDS_FIRE;
                    end
                end
            end
            WDS_RUN_HALF: begin
                if (gate) begin
                    if (hit) begin
                        state_d = WDS_FIRE;
                    end else if (wr) begin
                        if (go_hit) begin
                            state_d = WDS_RUN;
                            service = 1'b1;
                        end else begin
                            state_d = WDS_FIRE;
                        end
                    end
                end
            end
            WDS_FIRE: begin
                if (pulse_last) state_d = WDS_IDLE;
            end
            default: state_d = WDS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WDS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Counter and pulse control derived from the current state.
    always_comb begin
        running     = (state_q == WDS_RUN) || (state_q == WDS_RUN_HALF);
        cnt_inc     = running && gate;
        cnt_clr     = !running || service;
        pulse_start = (state_q != WDS_FIRE) && (state_d == WDS_FIRE);
    end

    assign state = state_q;

endmodule

// File: rtl/wdog_keyed_reset.sv
// Keyed watchdog top: decodes control writes, sequences the key states,
// runs the joined timeout counter and emits the reset pulse.
// Assumes: all inputs synchronous to clk; wr_data valid with wr_en.
module wdog_keyed_reset
    import wdk_pkg::*;
#(
    parameter int unsigned CTRL_W    = 32,
    parameter int unsigned KEY_LSB   = 16,
    parameter int unsigned KEY_W     = 16,
    parameter int unsigned EN_POS    = 14,
    parameter logic [KEY_W-1:0] KEY_ARM = 16'hA5C6,
    parameter logic [KEY_W-1:0] KEY_GO  = 16'hDA7E,
    parameter int unsigned HALF_W    = 32,
    parameter int unsigned PULSE_LEN = 16,
    parameter logic [1:0]  MODE_WDOG = 2'b10,
    localparam int unsigned CNT_W    = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        tmode,
    input  logic [1:0]        half_run,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic [HALF_W-1:0] period_lo,
    input  logic [HALF_W-1:0] period_hi,
    output logic              sys_rst,
    output logic [2:0]        wd_state,
    output logic [CNT_W-1:0]  count
);

    logic wd_gate;
    logic en_bit, arm_hit, go_hit;
    logic hit, cnt_clr, cnt_inc;
    logic pulse_start, pulse_last;
    wds_e state;

    // Watchdog operates only in its mode with both halves released.
    always_comb begin
        wd_gate = (tmode == MODE_WDOG) && (&half_run);
    end

    wdk_key_decode #(
        .CTRL_W (CTRL_W), .KEY_LSB(KEY_LSB), .KEY_W(KEY_W),
        .EN_POS (EN_POS), .KEY_ARM(KEY_ARM), .KEY_GO(KEY_GO)
    ) u_dec (
        .word   (wr_data),
        .en_bit (en_bit),
        .arm_hit(arm_hit),
        .go_hit (go_hit)
    );

    wdk_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate       (wd_gate),
        .wr         (wr_en),
        .en_bit     (en_bit),
        .arm_hit    (arm_hit),
        .go_hit     (go_hit),
        .hit        (hit),
        .pulse_last (pulse_last),
        .state      (state),
        .cnt_clr    (cnt_clr),
        .cnt_inc    (cnt_inc),
        .pulse_start(pulse_start)
    );

    wdk_span_counter #(.HALF_W(HALF_W), .HALVES(2)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .period({period_hi, period_lo}),
        .cnt   (count),
        .hit   (hit)
    );

    wdk_rst_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (pulse_start),
        .active(sys_rst),
        .last  (pulse_last)
    );

    assign wd_state = state;

endmodule

// File: rtl/wdk_checker.sv
// Cycle-level properties of the keyed watchdog, bound to its top.
// Assumes: state codes from wdk_pkg; PULSE_LEN matches the top.
module wdk_checker
    import wdk_pkg::*;
#(
    parameter int unsigned CTRL_W    = 32,
    parameter int unsigned KEY_LSB   = 16,
    parameter int unsigned KEY_W     = 16,
    parameter logic [KEY_W-1:0] KEY_ARM = 16'hA5C6,
    parameter int unsigned CNT_W     = 64,
    parameter int unsigned PULSE_LEN = 16,
    localparam int unsigned RW       = $clog2(PULSE_LEN + 1) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gate,
    input logic              wr_en,
    input logic [CTRL_W-1:0] wr_data,
    input logic              sys_rst,
    input logic [2:0]        wd_state,
    input logic [CNT_W-1:0]  count
);

    logic [RW-1:0] hi_run;

    // Length of the current run of high sys_rst cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
        end else if (sys_rst) begin
            if (hi_run != '1) hi_run <= hi_run + 1'b1;
        end else begin
            hi_run <= '0;
        end
    end

    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> (hi_run < RW'(PULSE_LEN))); // R9
    AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> (hi_run == RW'(PULSE_LEN))); // R9
    AST_PULSE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> (wd_state == WDS_IDLE)); // R9
    AST_PULSE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> (wd_state == WDS_FIRE)); // R9
    AST_ZERO_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_state == WDS_IDLE || wd_state == WDS_PRE) |-> (count == '0)); // R5
    AST_PRE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_state == WDS_PRE && $past(wd_state) != WDS_PRE)
        |-> ($past(wd_state) == WDS_IDLE)); // R3
    AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_state == WDS_RUN && $past(wd_state) != WDS_RUN
         && $past(wd_state) != WDS_RUN_HALF)
        |-> ($past(wd_state) == WDS_PRE)); // R4
    AST_NO_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wd_state) == WDS_RUN || $past(wd_state) == WDS_RUN_HALF)
        |-> (wd_state != WDS_IDLE && wd_state != WDS_PRE)); // R10
    AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && wr_en && wd_state == WDS_RUN
         && wr_data[KEY_LSB +: KEY_W] != KEY_ARM) |=> sys_rst); // R8
    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && wd_state != WDS_FIRE)
        |=> ($stable(wd_state) && $stable(count))); // R2

endmodule

bind wdog_keyed_reset wdk_checker #(
    .CTRL_W   (CTRL_W),
    .KEY_LSB  (KEY_LSB),
    .KEY_W    (KEY_W),
    .KEY_ARM  (KEY_ARM),
    .CNT_W    (CNT_W),
    .PULSE_LEN(PULSE_LEN)
) u_wdk_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .gate    (wd_gate),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .sys_rst (sys_rst),
    .wd_state(wd_state),
    .count   (count)
);

// File: tb/wdog_keyed_reset_test.sv
`timescale 1ns/1ps
module wdog_keyed_reset_test;

    localparam int PLEN = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  tmode = 2'b10;
    logic [1:0]  half_run = 2'b11;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] period_lo = '0;
    logic [31:0] period_hi = '0;
    logic        sys_rst;
    logic [2:0]  wd_state;
    logic [63:0] count;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    wdog_keyed_reset uut (
        .clk(clk), .rst_n(rst_n), .tmode(tmode), .half_run(half_run),
        .wr_en(wr_en), .wr_data(wr_data), .period_lo(period_lo),
        .period_hi(period_hi), .sys_rst(sys_rst), .wd_state(wd_state),
        .count(count)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic arm();
        wr(32'hA5C6_4000);
        wr(32'hDA7E_4000);
    endtask

    // Count the remaining high cycles of the pulse, starting at a high sample.
    task automatic pulse_rest(input int already, input string req);
        int n = already;
        while (sys_rst === 1'b1 && n < 4 * PLEN) begin
            n++;
            @(negedge clk);
        end
        chk(n == PLEN, req, n, PLEN);
        chk(wd_state == 3'd0 && count == 0, req, wd_state, 0);
    endtask

    initial begin
        logic [15:0] run_bad [5];
        logic [15:0] half_bad [3];
        run_bad  = '{16'h0000, 16'hDA7E, 16'hFFFF, 16'hA5C7, 16'h1234};
        half_bad = '{16'hA5C6, 16'h0000, 16'hDA7F};

        // R1 reset state
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(wd_state == 3'd0, "R1 state", wd_state, 0);
        chk(sys_rst == 1'b0, "R1 sys_rst", sys_rst, 0);
        chk(count == 0, "R1 count", count, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 ignored writes while disarmed
        wr(32'hDA7E_4000); chk(wd_state == 3'd0, "R3 go key first", wd_state, 0);
        wr(32'hA5C6_0000); chk(wd_state == 3'd0, "R3 enable clear", wd_state, 0);
        wr(32'h1234_4000); chk(wd_state == 3'd0, "R3 other key", wd_state, 0);
        wr(32'hA5C6_4000); chk(wd_state == 3'd1, "R3 arm", wd_state, 1);
        // R4 ignored writes while primed
        wr(32'hA5C6_4000); chk(wd_state == 3'd1, "R4 repeat arm", wd_state, 1);
        wr(32'hDA7E_0000); chk(wd_state == 3'd1, "R4 enable clear", wd_state, 1);
        wr(32'h0000_4000); chk(wd_state == 3'd1, "R4 zero key", wd_state, 1);
        wr(32'hDA7E_4000);
        chk(wd_state == 3'd2 && count == 0, "R4 run", wd_state, 2);

        // R2 gate sweep: every non-watchdog configuration blocks arming
        for (int tm = 0; tm < 4; tm++) begin
            for (int hr = 0; hr < 4; hr++) begin
                if (!(tm == 2 && hr == 3)) begin
                    do_reset();
                    tmode = 2'(tm);
                    half_run = 2'(hr);
                    wr(32'hA5C6_4000);
                    chk(wd_state == 3'd0, "R2 gated arm", wd_state, 0);
                    tmode = 2'b10;
                    half_run = 2'b11;
                end
            end
        end

        // R2 freeze while running
        do_reset();
        period_hi = 0; period_lo = 100;
        arm();
        repeat (3) @(negedge clk);
        chk(count == 3, "R5 count 3", count, 3);
        half_run = 2'b01;
        repeat (5) @(negedge clk);
        chk(count == 3 && wd_state == 3'd2, "R2 frozen count", count, 3);
        wr(32'h0000_4000);
        chk(sys_rst == 1'b0 && wd_state == 3'd2, "R2 gated bad key", wd_state, 2);
        half_run = 2'b11;
        repeat (2) @(negedge clk);
        chk(count == 5, "R2 resumed count", count, 5);

        // R5 R6 R9 timeout sweep over small periods
        for (int p = 0; p < 7; p++) begin
            do_reset();
            period_hi = 0; period_lo = p;
            arm();
            for (int k = 0; k <= p; k++) begin
                chk(count == 64'(k) && sys_rst == 1'b0, "R5 count step", count, k);
                if (k < p) @(negedge clk);
            end
            @(negedge clk);
            chk(sys_rst == 1'b1 && wd_state == 3'd4, "R6 timeout", sys_rst, 1);
            pulse_rest(0, "R9 pulse after timeout");
        end

        // R6 high half joins the compare
        do_reset();
        period_hi = 1; period_lo = 2;
        arm();
        repeat (5) @(negedge clk);
        chk(sys_rst == 1'b0 && count == 5, "R6 high half", count, 5);

        // R6 timeout beats a same-edge service write
        do_reset();
        period_hi = 0; period_lo = 3;
        arm();
        repeat (3) @(negedge clk);
        wr(32'hA5C6_4000);
        chk(sys_rst == 1'b1, "R6 precedence", sys_rst, 1);
        pulse_rest(0, "R9 pulse after precedence");

        // R7 service restarts the count
        do_reset();
        period_hi = 0; period_lo = 20;
        arm();
        repeat (10) @(negedge clk);
        chk(count == 10, "R5 count 10", count, 10);
        wr(32'hA5C6_4000);
        chk(wd_state == 3'd3 && count == 11, "R7 half service", count, 11);
        wr(32'hDA7E_4000);
        chk(wd_state == 3'd2 && count == 0, "R7 service clear", count, 0);
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            chk(sys_rst == 1'b0 && count == 64'(k), "R7 recount", count, k);
        end
        @(negedge clk);
        chk(sys_rst == 1'b1, "R7 timeout after service", sys_rst, 1);
        pulse_rest(0, "R9 pulse after service");

        // R7 enable flag ignored while running
        do_reset();
        period_lo = 1000;
        arm();
        wr(32'hA5C6_0000);
        chk(wd_state == 3'd3, "R7 no enable half", wd_state, 3);
        wr(32'hDA7E_0000);
        chk(wd_state == 3'd2 && count == 0, "R7 no enable service", wd_state, 2);
        chk(sys_rst == 1'b0, "R10 still running", sys_rst, 0);

        // R8 bad keys in the running state
        for (int i = 0; i < 5; i++) begin
            do_reset();
            period_lo = 1000;
            arm();
            wr({run_bad[i], 16'h4000});
            chk(sys_rst == 1'b1 && wd_state == 3'd4, "R8 bad key run", run_bad[i], 1);
            pulse_rest(0, "R9 pulse after bad key");
        end
        // R8 bad keys in the half-serviced state
        for (int i = 0; i < 3; i++) begin
            do_reset();
            period_lo = 1000;
            arm();
            wr(32'hA5C6_4000);
            wr({half_bad[i], 16'h4000});
            chk(sys_rst == 1'b1 && wd_state == 3'd4, "R8 bad key half", half_bad[i], 1);
            pulse_rest(0, "R10 pulse exit");
        end

        // R11 writes and gate during the pulse change nothing
        do_reset();
        period_lo = 1000;
        arm();
        wr(32'h0000_4000);
        chk(sys_rst == 1'b1, "R11 fire", sys_rst, 1);
        wr_en = 1'b1; wr_data = 32'hA5C6_4000; tmode = 2'b00;
        @(negedge clk);
        wr_en = 1'b0;
        pulse_rest(1, "R11 pulse length");
        tmode = 2'b10;
        @(negedge clk);
        chk(wd_state == 3'd0, "R11 write ignored", wd_state, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule